// File: doc/BRIEF.md
# Entry-Delay Intrusion Alarm Controller

This block controls an intruder alarm from a single system clock. An arm switch and three sensor lines (front door, rear door, window) enter through two-flop synchronizers. A four-state machine has the states off, watching, entry delay and alarm. When any sensor trips while the system is armed, an entry-delay window opens. During the window the elapsed seconds appear on one active-low seven-segment digit. If the arm switch is not dropped before the count reaches the limit, the siren sounds.

A built-in divider turns the system clock into a one-cycle seconds tick, used as a clock enable. The divider ratio is a parameter, so a simulation can run with a short second. Dropping the arm switch acts as an overriding asynchronous clear: the state returns to off at once. Four indicator outputs copy the arm and sensor inputs without delay.

Top module: `entry_alarm_ctrl`

## Requirements
- R1: While arm_i is low, or rst_ni is low, the state is off: siren_o = 0, delay_run_o = 0 and the digit shows 0. A fall of arm_i clears the state asynchronously, with no clock edge needed.
- R2: The arm input passes two synchronizer flops, and the state moves from off to watching on the next edge after that. A sensor pulse that ends before the watching state is reached opens no delay.
- R3: In watching, a synchronized sensor vector with any bit set moves the state to entry delay. delay_run_o is high only in entry delay. A single sensor is enough. Bit 2 of sensor_i is the front door, bit 1 the rear door, bit 0 the window.
- R4: The divider raises a one-cycle tick every DIV_RATIO clocks. In entry delay the seconds count advances by one on each tick. The count is zero on entry and is zero in every other state.
- R5: When the count equals DELAY_SECS (default 7), the next edge enters the alarm state and clears the count. siren_o is high only in alarm. The time spent in entry delay lies between (DELAY_SECS-1)*DIV_RATIO+1 and DELAY_SECS*DIV_RATIO+2 clocks.
- R6: In alarm, the state holds while arm_i stays high, whatever the sensors do.
- R7: Dropping arm_i during entry delay returns the state to off, and siren_o is never asserted.
- R8: seg_no is active low with bits a,b,c,d,e,f,g,dp from MSB to LSB, and dp is always off. It shows the seconds count. Digits 0 to 7 encode as 03, 9F, 25, 0D, 99, 49, 41, 1F (hex).
- R9: dig_en_no is the active-low pattern 1110: only digit 0 is enabled.
- R10: arm_ind_o, front_ind_o, rear_ind_o and window_ind_o equal arm_i, sensor_i[2], sensor_i[1] and sensor_i[0] in the same cycle.
- R11: While disarmed, sensor activity never opens a delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm switch; low forces the off state |
| sensor_i | input | 3 | Sensors: [2] front, [1] rear, [0] window |
| siren_o | output | 1 | High in alarm |
| delay_run_o | output | 1 | High during entry delay |
| arm_ind_o | output | 1 | Copy of arm_i |
| front_ind_o | output | 1 | Copy of sensor_i[2] |
| rear_ind_o | output | 1 | Copy of sensor_i[1] |
| window_ind_o | output | 1 | Copy of sensor_i[0] |
| seg_no | output | 8 | Active-low segments a..g,dp (MSB..LSB) |
| dig_en_no | output | 4 | Active-low digit enables |

## Verification
Directed sequences cover the following cases:
- A rear-door trip followed by a disarm partway through the delay, which separates the abort path from the timeout path.
- A window sensor held until timeout, which shows the full count 0 to 7 and the move into alarm.
- Sensor changes in alarm, which show that the siren holds.
- A sensor pulse that arrives together with arm, which exposes the synchronizer latency.

Seeded random traffic then toggles arm rarely and pulses sensors at random lengths and phases relative to the tick. On every cycle, each output is compared with a cycle-exact reference model built from the requirements.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WATCH = 2'd1,
    ST_ENTRY = 2'd2,
    ST_ALARM = 2'd3
  } alarm_state_e;

  // active-low segments, {a,b,c,d,e,f,g,dp}, dp off
  function automatic logic [7:0] hex_to_seg_n(input logic [3:0] v);
    logic [6:0] lit;
    unique case (v)
      4'h0: lit = 7'b1111110;
      4'h1: lit = 7'b0110000;
      4'h2: lit = 7'b1101101;
      4'h3: lit = 7'b1111001;
      4'h4: lit = 7'b0110011;
      4'h5: lit = 7'b1011011;
      4'h6: lit = 7'b1011111;
      4'h7: lit = 7'b1110000;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1111011;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b0011111;
      4'hC: lit = 7'b1001110;
      4'hD: lit = 7'b0111101;
      4'hE: lit = 7'b1001111;
      default: lit = 7'b1000111;
    endcase
    return {~lit, 1'b1};
  endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/alarm_tick_div.sv
module alarm_tick_div #(
  parameter int DIV_RATIO = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
  import alarm_pkg::*;
#(
  parameter int DELAY_SECS = 7,
  localparam int CW = $clog2(DELAY_SECS + 1)
) (
  input  logic          clk_i,
  input  logic          arm_ok_ni,  // synchronized arm, async clear when low
  input  logic          trip_i,
  input  logic          tick_i,
  output alarm_state_e  state_o,
  output logic [CW-1:0] secs_o
);

  alarm_state_e  state_q, state_d;
  logic [CW-1:0] secs_q, secs_d;
  logic          done;

  assign done = (secs_q == CW'(DELAY_SECS));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   state_d = ST_WATCH;
      ST_WATCH: if (trip_i) state_d = ST_ENTRY;
      ST_ENTRY: if (done) state_d = ST_ALARM;
      default:  state_d = ST_ALARM;
    endcase
  end

  always_comb begin
    secs_d = '0;
    if (state_q == ST_ENTRY && !done) secs_d = tick_i ? secs_q + 1'b1 : secs_q;
  end

  always_ff @(posedge clk_i or negedge arm_ok_ni) begin
    if (!arm_ok_ni) begin
      state_q <= ST_OFF;
      secs_q  <= '0;
    end else begin
      state_q <= state_d;
      secs_q  <= secs_d;
    end
  end

  assign state_o = state_q;
  assign secs_o  = secs_q;

endmodule

// File: rtl/alarm_seg_dec.sv
module alarm_seg_dec
  import alarm_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [3:0]            digit_i,
  output logic [7:0]            seg_no,
  output logic [NUM_DIGITS-1:0] dig_en_no
);

  assign seg_no = hex_to_seg_n(digit_i);

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_en
    assign dig_en_no[d] = (d != 0);
  end

endmodule

// File: rtl/entry_alarm_ctrl.sv
module entry_alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int DIV_RATIO   = 50_000_000,
  parameter int DELAY_SECS  = 7,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_SENSORS = 3,
  parameter int NUM_DIGITS  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   arm_i,
  input  logic [NUM_SENSORS-1:0] sensor_i,
  output logic                   siren_o,
  output logic                   delay_run_o,
  output logic                   arm_ind_o,
  output logic                   front_ind_o,
  output logic                   rear_ind_o,
  output logic                   window_ind_o,
  output logic [7:0]             seg_no,
  output logic [NUM_DIGITS-1:0]  dig_en_no
);

  localparam int CW = $clog2(DELAY_SECS + 1);

  logic                   arm_rst_n;
  logic                   arm_ok_n;
  logic [NUM_SENSORS-1:0] sensor_s;
  logic                   tick;
  alarm_state_e           state;
  logic [CW-1:0]          secs;

  // arm low clears the arm synchronizer at once; rise is resynchronized
  assign arm_rst_n = rst_ni & arm_i;

  alarm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_arm_sync (
    .clk_i  (clk_i),
    .rst_ni (arm_rst_n),
    .d_i    (1'b1),
    .q_o    (arm_ok_n)
  );

  alarm_sync #(.WIDTH(NUM_SENSORS), .STAGES(SYNC_STAGES)) u_sens_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sensor_i),
    .q_o    (sensor_s)
  );

  alarm_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  alarm_fsm #(.DELAY_SECS(DELAY_SECS)) u_fsm (
    .clk_i     (clk_i),
    .arm_ok_ni (arm_ok_n),
    .trip_i    (|sensor_s),
    .tick_i    (tick),
    .state_o   (state),
    .secs_o    (secs)
  );

  alarm_seg_dec #(.NUM_DIGITS(NUM_DIGITS)) u_seg (
    .digit_i   (4'(secs)),
    .seg_no    (seg_no),
    .dig_en_no (dig_en_no)
  );

  assign siren_o      = (state == ST_ALARM);
  assign delay_run_o  = (state == ST_ENTRY);
  assign arm_ind_o    = arm_i;
  assign front_ind_o  = sensor_i[NUM_SENSORS-1];
  assign rear_ind_o   = sensor_i[NUM_SENSORS-2];
  assign window_ind_o = sensor_i[0];

endmodule

// File: rtl/alarm_chk.sv
module alarm_chk #(
  parameter int DIV_RATIO  = 50_000_000,
  parameter int DELAY_SECS = 7
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic       siren_o,
  input logic       delay_run_o,
  input logic [7:0] seg_no
);

  localparam longint MIN_RUN = longint'(DELAY_SECS - 1) * DIV_RATIO + 1;
  localparam longint MAX_RUN = longint'(DELAY_SECS) * DIV_RATIO + 2;

  longint run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_cnt_q <= 0;
    else if (delay_run_o) run_cnt_q <= run_cnt_q + 1;
    else                  run_cnt_q <= 0;
  end

  assert_disarm_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && $past(!arm_i)) |-> (!siren_o && !delay_run_o && seg_no == 8'h03));

  assert_entry_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delay_run_o) |-> seg_no == 8'h03);

  assert_siren_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(siren_o && delay_run_o));

  assert_alarm_from_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(siren_o) |-> $past(delay_run_o));

  assert_entry_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(siren_o) |-> (run_cnt_q >= MIN_RUN && run_cnt_q <= MAX_RUN));

  assert_alarm_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(siren_o) && arm_i && $past(arm_i)) |-> siren_o);

endmodule

bind entry_alarm_ctrl alarm_chk #(.DIV_RATIO(DIV_RATIO), .DELAY_SECS(DELAY_SECS)) u_chk (.*);

// File: tb/entry_alarm_ctrl_test.sv
module entry_alarm_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int DSECS      = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arm_i = 1'b0;
  logic [2:0] sensor_i = 3'b000;
  logic       siren_o, delay_run_o;
  logic       arm_ind_o, front_ind_o, rear_ind_o, window_ind_o;
  logic [7:0] seg_no;
  logic [3:0] dig_en_no;

  int n_chk = 0;
  int n_err = 0;
  bit siren_seen = 1'b0;

  entry_alarm_ctrl #(.DIV_RATIO(DIV), .DELAY_SECS(DSECS)) uut (
    .clk_i, .rst_ni, .arm_i, .sensor_i, .siren_o, .delay_run_o,
    .arm_ind_o, .front_ind_o, .rear_ind_o, .window_ind_o, .seg_no, .dig_en_no
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ---- reference model from the requirements ----
  int         r_div;
  logic [2:0] r_s1, r_s2;
  logic       r_a1, r_a2;
  int         r_st;   // 0 off, 1 watch, 2 entry, 3 alarm
  int         r_cnt;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin r_div <= 0; r_s1 <= 0; r_s2 <= 0; end
    else begin
      r_div <= (r_div == DIV-1) ? 0 : r_div + 1;
      r_s1 <= sensor_i; r_s2 <= r_s1;
    end

  always @(posedge clk_i or negedge rst_ni or negedge arm_i)
    if (!rst_ni || !arm_i) begin r_a1 <= 0; r_a2 <= 0; end
    else begin r_a1 <= 1'b1; r_a2 <= r_a1; end

  always @(posedge clk_i or negedge r_a2)
    if (!r_a2) begin r_st <= 0; r_cnt <= 0; end
    else case (r_st)
      0: r_st <= 1;
      1: if (|r_s2) r_st <= 2;
      2: if (r_cnt == DSECS) begin r_st <= 3; r_cnt <= 0; end
         else if (r_div == DIV-1) r_cnt <= r_cnt + 1;
      default: r_st <= 3;
    endcase

  function automatic logic [7:0] seg_exp(int d);
    case (d)
      0: return 8'h03; 1: return 8'h9F; 2: return 8'h25; 3: return 8'h0D;
      4: return 8'h99; 5: return 8'h49; 6: return 8'h41; 7: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (siren_o === 1'b1) siren_seen = 1'b1;
    if (rst_ni) begin
      chk(siren_o === (r_st == 3), "R5", "siren", 32'(siren_o), 32'(r_st == 3));
      chk(delay_run_o === (r_st == 2), "R3", "delay_run", 32'(delay_run_o), 32'(r_st == 2));
      chk(seg_no === seg_exp(r_cnt), "R8", "seg", 32'(seg_no), 32'(seg_exp(r_cnt)));
      chk(dig_en_no === 4'b1110, "R9", "dig_en", 32'(dig_en_no), 32'hE);
      chk({arm_ind_o, front_ind_o, rear_ind_o, window_ind_o} === {arm_i, sensor_i},
          "R10", "indicators", 32'({arm_ind_o, front_ind_o, rear_ind_o, window_ind_o}),
          32'({arm_i, sensor_i}));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
    #2;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL R5 watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] prev_seg;
    void'($urandom(32'h1A5E_0007));
    step(4);
    chk(siren_o === 1'b0 && delay_run_o === 1'b0, "R1", "reset quiet",
        32'({siren_o, delay_run_o}), 32'h0);
    chk(seg_no === 8'h03, "R1", "reset digit", 32'(seg_no), 32'h03);
    chk(dig_en_no === 4'b1110, "R9", "reset dig_en", 32'(dig_en_no), 32'hE);
    rst_ni = 1'b1;
    step(3);

    // R11: disarmed sensors are ignored
    sensor_i = 3'b111;
    step(20);
    chk(delay_run_o === 1'b0, "R11", "no delay while disarmed", 32'(delay_run_o), 32'h0);
    sensor_i = 3'b000;
    step(2);

    // R2: pulse together with arm rise is lost to sync latency
    arm_i = 1'b1; sensor_i = 3'b100;
    step(1);
    sensor_i = 3'b000;
    step(6);
    chk(delay_run_o === 1'b0, "R2", "early pulse ignored", 32'(delay_run_o), 32'h0);

    // R3/R7: rear door trip, abort by disarm
    siren_seen = 1'b0;
    sensor_i = 3'b010;
    step(1);
    sensor_i = 3'b000;
    step(4);
    chk(delay_run_o === 1'b1, "R3", "rear door opens delay", 32'(delay_run_o), 32'h1);
    step(3*DIV);
    arm_i = 1'b0;
    #1;
    chk(delay_run_o === 1'b0 && siren_o === 1'b0, "R1", "async disarm",
        32'({siren_o, delay_run_o}), 32'h0);
    step(10*DIV);
    chk(siren_seen == 1'b0, "R7", "siren never seen", 32'(siren_seen), 32'h0);

    // R5: window held to timeout
    arm_i = 1'b1;
    step(5);
    sensor_i = 3'b001;
    prev_seg = seg_no;
    for (int i = 0; i < 12*DIV; i++) begin
      prev_seg = seg_no;
      step(1);
      if (siren_o === 1'b1) break;
    end
    chk(siren_o === 1'b1, "R5", "alarm after delay", 32'(siren_o), 32'h1);
    chk(prev_seg === 8'h1F, "R8", "last digit 7", 32'(prev_seg), 32'h1F);
    chk(seg_no === 8'h03, "R4", "count cleared in alarm", 32'(seg_no), 32'h03);

    // R6: alarm holds whatever the sensors do
    sensor_i = 3'b000;
    step(30);
    chk(siren_o === 1'b1, "R6", "hold, sensors idle", 32'(siren_o), 32'h1);
    sensor_i = 3'b110;
    step(5);
    chk(siren_o === 1'b1, "R6", "hold, sensors active", 32'(siren_o), 32'h1);
    arm_i = 1'b0;
    #1;
    chk(siren_o === 1'b0, "R1", "disarm clears alarm", 32'(siren_o), 32'h0);
    sensor_i = 3'b000;
    step(3);

    // random traffic, compared each cycle against the model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 199) == 0) arm_i = ~arm_i;
      else if (!arm_i && $urandom_range(0, 19) == 0) arm_i = 1'b1;
      if ($urandom_range(0, 29) == 0) sensor_i = 3'($urandom_range(0, 7));
      else if ($urandom_range(0, 3) == 0) sensor_i = 3'b000;
      step(1);
    end

    step(2);
    summary();
    $finish;
  end

endmodule